// File: doc/BRIEF.md
# Lockable Tag Memory Controller

This block is the storage and state core of a contactless memory tag. It keeps a user memory of 32 words of 32 bits in registers, each word with a write-once lock bit. It also keeps two 8-bit identifier registers, one for the application family and one for the storage format, each with its own one-time lock. A 32-bit kill code has its own write request and lock. A fixed 64-bit unique identifier comes in on a port and can only be read.

Requests arrive already decoded as an opcode, a select flag, an address, a block count and a 32-bit data word. One request is taken per cycle while the block is not busy. Each accepted request produces a registered response one cycle later: a valid strobe, a last-beat flag, a 2-bit error code, a data word and a lock bit. Multi-block reads and identifier reads stream further beats on consecutive cycles. While beats are still pending, `busy` is high and new requests are dropped.

The block also tracks the tag's protocol state: ready, selected, quiet or killed. Killed is permanent until reset, and a killed tag answers nothing. Radio coding, anticollision slotting and non-volatile write timing are handled elsewhere.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset the tag is in the ready state, every user word, both identifier registers and the kill code read as zero, nothing is locked, `busy` is low and no response is pending.
- R2: Opcode 6 (write word) with address below 32 replaces all 32 bits of an unlocked word and answers error 0. Opcode 5 (read word) answers one cycle after the request with the word in `rsp_data` and its lock bit in `rsp_lock`.
- R3: Opcode 7 (lock word) sets a word's lock bit and the bit can never be cleared. A write or a lock aimed at a locked word answers error 1 and leaves the word unchanged.
- R4: A read, write or lock with address 32 or above, or a multi-read whose last word would be above 31, answers error 2 and changes nothing. Every error response is a single beat with `rsp_last` high and `rsp_data` zero.
- R5: Opcode 8 (multi-read) with address a and count n answers n+1 beats on consecutive cycles, for words a to a+n in ascending order, with `rsp_last` high only on the final beat. `busy` is high while beats are pending, and any request that arrives while `busy` is high is dropped with no response.
- R6: Opcodes 9 and 11 write the application-family and storage-format registers from `req_data[7:0]`. Opcodes 10 and 12 lock them once, and a write after the lock answers error 1 and leaves the value unchanged. Opcode 16 answers with the application-family value in bits 7:0, the storage-format value in bits 15:8, and the lock flags for the application-family register, the storage-format register and the kill code in bits 16, 17 and 18.
- R7: Opcode 13 writes the kill code and opcode 14 locks it; a write after the lock answers error 1. Opcode 15 (kill) whose data differs from the stored code answers error 3 and the tag stays active. A matching kill answers error 0, and from then on no request gets any response until reset.
- R8: Opcode 1 (inventory) answers two beats: the identifier's low 32 bits, then its high 32 bits with `rsp_last`. In the quiet state, entered with opcode 2, inventory gets no response, but other requests are still served.
- R9: Opcode 3 enters the selected state and opcode 4 returns to ready; both answer error 0. A request with `req_sel` high is served only in the selected state, and in any other state it gets no response.
- R10: Opcode 0 gets no response. Any opcode above 16 answers error 3 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_op | input | 5 | Request opcode |
| req_sel | input | 1 | Request is addressed only to a selected tag |
| req_addr | input | 8 | Word address, or first word of a multi-read |
| req_cnt | input | 5 | Extra words in a multi-read |
| req_data | input | 32 | Write data, or kill code to compare |
| uid | input | 64 | Fixed unique identifier |
| busy | output | 1 | Beats pending; requests are dropped |
| rsp_valid | output | 1 | Response beat valid |
| rsp_last | output | 1 | Final beat of a response |
| rsp_err | output | 2 | 0 ok, 1 locked, 2 out of range, 3 denied |
| rsp_data | output | 32 | Response data |
| rsp_lock | output | 1 | Lock bit of the word returned |

## Verification
On every cycle the assertions check four things: lock bits only ever go from clear to set, the killed state never leaves and never answers, a burst that is not on its last beat is followed by another beat, and every pending beat is delivered. They also check that every error response is a single beat carrying no data. Some behaviour only shows up in the bench's scenarios:
- data actually being kept or refused after a locked write
- the ascending order of multi-read words
- silent dropping of a request sent during a burst
- kill code comparison
- quiet-state filtering of inventory
- the select-flag rules

// File: rtl/tagmem_pkg.sv
// Shared opcode, error and state encodings for the tag memory controller.
package tagmem_pkg;
    typedef enum logic [4:0] {
        OP_NOP       = 5'd0,
        OP_INVENTORY = 5'd1,
        OP_QUIET     = 5'd2,
        OP_SELECT    = 5'd3,
        OP_TO_READY  = 5'd4,
        OP_RD_WORD   = 5'd5,
        OP_WR_WORD   = 5'd6,
        OP_LK_WORD   = 5'd7,
        OP_RD_MULTI  = 5'd8,
        OP_WR_FAM    = 5'd9,
        OP_LK_FAM    = 5'd10,
        OP_WR_FMT    = 5'd11,
        OP_LK_FMT    = 5'd12,
        OP_WR_KILL   = 5'd13,
        OP_LK_KILL   = 5'd14,
        OP_KILL      = 5'd15,
        OP_GET_INFO  = 5'd16
    } tag_op_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_LOCKED = 2'd1,
        ERR_RANGE  = 2'd2,
        ERR_DENIED = 2'd3
    } tag_err_e;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_SELECTED = 2'd1,
        ST_QUIET    = 2'd2,
        ST_KILLED   = 2'd3
    } tag_state_e;
endpackage

// File: rtl/tagmem_store.sv
// User word array with one write-once lock bit per word.
// Assumes the caller checks address range; a write to a locked word is
// refused here as well, so the array never changes once a word is locked.
module tagmem_store #(
    parameter  int NBLK = 32,
    parameter  int DW   = 32,
    localparam int BAW  = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            lk_en,
    input  logic [BAW-1:0]  wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [BAW-1:0]  rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            rd_lock,
    output logic [NBLK-1:0] lock_vec
);
    logic [DW-1:0] words [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_word
        logic [DW-1:0] word_q;
        logic          lock_q;
        logic          hit;

        assign hit = (wr_addr == BAW'(g));

        // Hold one word and its lock; the lock gates writes and never clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                lock_q <= 1'b0;
            end else begin
                if (wr_en && hit && !lock_q) word_q <= wr_data;
                if (lk_en && hit)            lock_q <= 1'b1;
            end
        end

        assign words[g]    = word_q;
        assign lock_vec[g] = lock_q;
    end

    // Combinational read port shared by single and burst reads.
    always_comb begin
        rd_data = words[rd_addr];
        rd_lock = lock_vec[rd_addr];
    end
endmodule

// File: rtl/tagmem_lreg.sv
// A register with a one-time lock: writes land only while unlocked, and
// once set the lock stays set until reset.
module tagmem_lreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         lk_set,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         locked
);
    // Update value while unlocked and latch the lock permanently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            locked <= 1'b0;
        end else begin
            if (we && !locked) q <= d;
            if (lk_set)        locked <= 1'b1;
        end
    end
endmodule

// File: rtl/tagmem_regs.sv
// The two 8-bit identifier registers and the kill code, each lockable once.
// Assumes write and lock strobes are already qualified by the decoder.
module tagmem_regs #(
    parameter  int DW = 32,
    localparam int IDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fam_we,
    input  logic           fam_lk,
    input  logic           fmt_we,
    input  logic           fmt_lk,
    input  logic           kill_we,
    input  logic           kill_lk,
    input  logic [DW-1:0]  wdata,
    output logic [IDW-1:0] fam,
    output logic [IDW-1:0] fmt,
    output logic [DW-1:0]  kill_code,
    output logic           fam_locked,
    output logic           fmt_locked,
    output logic           kill_locked
);
    tagmem_lreg #(.W(IDW)) u_fam (
        .clk(clk), .rst_n(rst_n), .we(fam_we), .lk_set(fam_lk),
        .d(wdata[IDW-1:0]), .q(fam), .locked(fam_locked)
    );

    tagmem_lreg #(.W(IDW)) u_fmt (
        .clk(clk), .rst_n(rst_n), .we(fmt_we), .lk_set(fmt_lk),
        .d(wdata[IDW-1:0]), .q(fmt), .locked(fmt_locked)
    );

    tagmem_lreg #(.W(DW)) u_kill (
        .clk(clk), .rst_n(rst_n), .we(kill_we), .lk_set(kill_lk),
        .d(wdata), .q(kill_code), .locked(kill_locked)
    );
endmodule

// File: rtl/tagmem_state.sv
// Protocol state of the tag: ready, selected, quiet, killed.
// Killed absorbs every later event; kill outranks all other moves.
module tagmem_state
    import tagmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_ready,
    input  logic       go_select,
    input  logic       go_quiet,
    input  logic       go_kill,
    output tag_state_e st
);
    // Advance the protocol state on decoded state requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_READY;
        end else if (st != ST_KILLED) begin
            if (go_kill)        st <= ST_KILLED;
            else if (go_ready)  st <= ST_READY;
            else if (go_select) st <= ST_SELECTED;
            else if (go_quiet)  st <= ST_QUIET;
        end
    end
endmodule

// File: rtl/tagmem_ctrl.sv
// Top of the tag memory controller. Decodes one request per idle cycle,
// applies it to storage and state, and returns a registered response one
// cycle later. Multi-word reads and identifier reads continue as a burst,
// one beat per cycle, during which requests are dropped.
// Assumes requests are single-cycle strobes and the identifier is static.
module tagmem_ctrl
    import tagmem_pkg::*;
#(
    parameter  int NBLK = 32,
    parameter  int DW   = 32,
    parameter  int ADRW = 8,
    localparam int BAW  = $clog2(NBLK),
    localparam int OPW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [OPW-1:0]  req_op,
    input  logic            req_sel,
    input  logic [ADRW-1:0] req_addr,
    input  logic [BAW-1:0]  req_cnt,
    input  logic [DW-1:0]   req_data,
    input  logic [2*DW-1:0] uid,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_last,
    output logic [1:0]      rsp_err,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_lock
);
    localparam logic [ADRW:0] NBLK_V = (ADRW+1)'(NBLK);
    localparam int IDW = 8;

    tag_state_e      st;
    logic [BAW-1:0]  blk;
    logic [ADRW:0]   end_addr;
    logic            addr_ok, multi_ok, acc;
    logic [BAW-1:0]  rd_addr;
    logic [DW-1:0]   rd_data;
    logic            rd_lock;
    logic [NBLK-1:0] lock_vec;
    logic            wr_en, lk_en;
    logic            fam_we, fam_lk, fmt_we, fmt_lk, kill_we, kill_lk;
    logic [IDW-1:0]  fam, fmt;
    logic [DW-1:0]   kill_code;
    logic            fam_locked, fmt_locked, kill_locked;
    logic            go_ready, go_select, go_quiet, go_kill;
    logic            start_burst, start_uid;
    logic [BAW-1:0]  start_cnt;
    logic [BAW-1:0]  burst_left, burst_addr;
    logic            burst_uid;
    logic            d_valid, d_last, d_lock;
    tag_err_e        d_err;
    logic [DW-1:0]   d_data;

    assign blk      = req_addr[BAW-1:0];
    assign addr_ok  = {1'b0, req_addr} < NBLK_V;
    assign end_addr = {1'b0, req_addr} + (ADRW+1)'(req_cnt);
    assign multi_ok = end_addr < NBLK_V;
    assign busy     = (burst_left != '0);
    assign acc      = req_valid && !busy && (st != ST_KILLED)
                      && (!req_sel || st == ST_SELECTED);
    assign rd_addr  = busy ? burst_addr : blk;

    tagmem_store #(.NBLK(NBLK), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lk_en(lk_en),
        .wr_addr(blk), .wr_data(req_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_lock(rd_lock), .lock_vec(lock_vec)
    );

    tagmem_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .fam_we(fam_we), .fam_lk(fam_lk), .fmt_we(fmt_we), .fmt_lk(fmt_lk),
        .kill_we(kill_we), .kill_lk(kill_lk), .wdata(req_data),
        .fam(fam), .fmt(fmt), .kill_code(kill_code),
        .fam_locked(fam_locked), .fmt_locked(fmt_locked),
        .kill_locked(kill_locked)
    );

    tagmem_state u_state (
        .clk(clk), .rst_n(rst_n), .go_ready(go_ready), .go_select(go_select),
        .go_quiet(go_quiet), .go_kill(go_kill), .st(st)
    );

    // Decode an accepted request, or emit the next pending burst beat.
    always_comb begin
        d_valid = 1'b0;  d_last = 1'b1;  d_err = ERR_NONE;
        d_data  = '0;    d_lock = 1'b0;
        wr_en   = 1'b0;  lk_en  = 1'b0;
        fam_we  = 1'b0;  fam_lk = 1'b0;  fmt_we = 1'b0;  fmt_lk = 1'b0;
        kill_we = 1'b0;  kill_lk = 1'b0;
        go_ready = 1'b0; go_select = 1'b0; go_quiet = 1'b0; go_kill = 1'b0;
        start_burst = 1'b0; start_uid = 1'b0; start_cnt = '0;
        if (busy) begin
            d_valid = 1'b1;
            d_last  = (burst_left == BAW'(1));
            d_data  = burst_uid ? uid[2*DW-1:DW] : rd_data;
            d_lock  = burst_uid ? 1'b0 : rd_lock;
        end else if (acc) begin
            d_valid = 1'b1;
            case (tag_op_e'(req_op))
                OP_NOP: d_valid = 1'b0;
                OP_INVENTORY: begin
                    if (st == ST_QUIET) begin
                        d_valid = 1'b0;
                    end else begin
                        d_last      = 1'b0;
                        d_data      = uid[DW-1:0];
                        start_burst = 1'b1;
                        start_uid   = 1'b1;
                        start_cnt   = BAW'(1);
                    end
                end
                OP_QUIET:    go_quiet  = 1'b1;
                OP_SELECT:   go_select = 1'b1;
                OP_TO_READY: go_ready  = 1'b1;
                OP_RD_WORD: begin
                    if (!addr_ok) d_err = ERR_RANGE;
                    else begin
                        d_data = rd_data;
                        d_lock = rd_lock;
                    end
                end
                OP_WR_WORD: begin
                    if (!addr_ok)     d_err = ERR_RANGE;
                    else if (rd_lock) d_err = ERR_LOCKED;
                    else              wr_en = 1'b1;
                end
                OP_LK_WORD: begin
                    if (!addr_ok)     d_err = ERR_RANGE;
                    else if (rd_lock) d_err = ERR_LOCKED;
                    else              lk_en = 1'b1;
                end
                OP_RD_MULTI: begin
                    if (!multi_ok) d_err = ERR_RANGE;
                    else begin
                        d_data = rd_data;
                        d_lock = rd_lock;
                        if (req_cnt != '0) begin
                            d_last      = 1'b0;
                            start_burst = 1'b1;
                            start_cnt   = req_cnt;
                        end
                    end
                end
                OP_WR_FAM:  if (fam_locked)  d_err = ERR_LOCKED; else fam_we  = 1'b1;
                OP_LK_FAM:  if (fam_locked)  d_err = ERR_LOCKED; else fam_lk  = 1'b1;
                OP_WR_FMT:  if (fmt_locked)  d_err = ERR_LOCKED; else fmt_we  = 1'b1;
                OP_LK_FMT:  if (fmt_locked)  d_err = ERR_LOCKED; else fmt_lk  = 1'b1;
                OP_WR_KILL: if (kill_locked) d_err = ERR_LOCKED; else kill_we = 1'b1;
                OP_LK_KILL: if (kill_locked) d_err = ERR_LOCKED; else kill_lk = 1'b1;
                OP_KILL: begin
                    if (req_data == kill_code) go_kill = 1'b1;
                    else                       d_err   = ERR_DENIED;
                end
                OP_GET_INFO: begin
                    d_data = DW'({kill_locked, fmt_locked, fam_locked, fmt, fam});
                end
                default: d_err = ERR_DENIED;
            endcase
        end
    end

    // Track remaining burst beats and the next word to read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_left <= '0;
            burst_addr <= '0;
            burst_uid  <= 1'b0;
        end else if (start_burst) begin
            burst_left <= start_cnt;
            burst_addr <= blk + 1'b1;
            burst_uid  <= start_uid;
        end else if (busy) begin
            burst_left <= burst_left - 1'b1;
            burst_addr <= burst_addr + 1'b1;
        end
    end

    // Register the response beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_err   <= ERR_NONE;
            rsp_data  <= '0;
            rsp_lock  <= 1'b0;
        end else begin
            rsp_valid <= d_valid;
            rsp_last  <= d_valid && d_last;
            rsp_err   <= d_valid ? d_err : ERR_NONE;
            rsp_data  <= d_valid ? d_data : '0;
            rsp_lock  <= d_valid && d_lock;
        end
    end
endmodule

// File: rtl/tagmem_chk.sv
// Property checker for tagmem_ctrl, attached through bind.
module tagmem_chk
    import tagmem_pkg::*;
#(
    parameter int NBLK = 32,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input tag_state_e      st,
    input logic [NBLK-1:0] lock_vec,
    input logic            busy,
    input logic            rsp_valid,
    input logic            rsp_last,
    input logic [1:0]      rsp_err,
    input logic [DW-1:0]   rsp_data
);
    logic armed;

    // Arm one-cycle history checks only after a clean post-reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

    a_r7_kill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KILLED) |=> (st == ST_KILLED));

    a_r7_killed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KILLED) |=> !rsp_valid);

    a_r5_burst_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    a_r5_busy_beat: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> rsp_valid);

    a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != 2'd0) |-> (rsp_last && rsp_data == '0));
endmodule

bind tagmem_ctrl tagmem_chk #(.NBLK(NBLK), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .lock_vec(lock_vec), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .rsp_data(rsp_data)
);

// File: tb/tagmem_ctrl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// scenarios for bursts, identifier reads, quiet state, kill and reset.
module tagmem_ctrl_tb;
    import tagmem_pkg::*;

    localparam logic [63:0] UID_V = 64'h0123_4567_89AB_CDEF;

    typedef struct packed {
        logic [4:0]  op;
        logic        sel;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        ev;
        logic [1:0]  eerr;
        logic [31:0] edata;
        logic        elock;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{OP_RD_WORD,  1'b0, 8'd3,   32'h0,          1'b1, 2'd0, 32'h0,          1'b0, 8'd1}, // R1
        '{OP_WR_WORD,  1'b0, 8'd3,   32'hA5A5_0001,  1'b1, 2'd0, 32'h0,          1'b0, 8'd2}, // R2
        '{OP_RD_WORD,  1'b0, 8'd3,   32'h0,          1'b1, 2'd0, 32'hA5A5_0001,  1'b0, 8'd2}, // R2
        '{OP_LK_WORD,  1'b0, 8'd3,   32'h0,          1'b1, 2'd0, 32'h0,          1'b0, 8'd3}, // R3
        '{OP_WR_WORD,  1'b0, 8'd3,   32'hFFFF_FFFF,  1'b1, 2'd1, 32'h0,          1'b0, 8'd3}, // R3
        '{OP_RD_WORD,  1'b0, 8'd3,   32'h0,          1'b1, 2'd0, 32'hA5A5_0001,  1'b1, 8'd3}, // R3
        '{OP_LK_WORD,  1'b0, 8'd3,   32'h0,          1'b1, 2'd1, 32'h0,          1'b0, 8'd3}, // R3
        '{OP_WR_WORD,  1'b0, 8'd32,  32'h1234_5678,  1'b1, 2'd2, 32'h0,          1'b0, 8'd4}, // R4
        '{OP_RD_WORD,  1'b0, 8'd200, 32'h0,          1'b1, 2'd2, 32'h0,          1'b0, 8'd4}, // R4
        '{OP_WR_FAM,   1'b0, 8'd0,   32'h0000_003C,  1'b1, 2'd0, 32'h0,          1'b0, 8'd6}, // R6
        '{OP_LK_FAM,   1'b0, 8'd0,   32'h0,          1'b1, 2'd0, 32'h0,          1'b0, 8'd6}, // R6
        '{OP_WR_FAM,   1'b0, 8'd0,   32'h0000_0077,  1'b1, 2'd1, 32'h0,          1'b0, 8'd6}, // R6
        '{OP_WR_FMT,   1'b0, 8'd0,   32'h0000_0091,  1'b1, 2'd0, 32'h0,          1'b0, 8'd6}, // R6
        '{OP_GET_INFO, 1'b0, 8'd0,   32'h0,          1'b1, 2'd0, 32'h0001_913C,  1'b0, 8'd6}, // R6
        '{OP_WR_KILL,  1'b0, 8'd0,   32'hDEAD_BEEF,  1'b1, 2'd0, 32'h0,          1'b0, 8'd7}, // R7
        '{OP_KILL,     1'b0, 8'd0,   32'h1234_5678,  1'b1, 2'd3, 32'h0,          1'b0, 8'd7}, // R7
        '{OP_RD_WORD,  1'b1, 8'd3,   32'h0,          1'b0, 2'd0, 32'h0,          1'b0, 8'd9}, // R9
        '{OP_SELECT,   1'b0, 8'd0,   32'h0,          1'b1, 2'd0, 32'h0,          1'b0, 8'd9}, // R9
        '{OP_RD_WORD,  1'b1, 8'd3,   32'h0,          1'b1, 2'd0, 32'hA5A5_0001,  1'b1, 8'd9}, // R9
        '{OP_TO_READY, 1'b0, 8'd0,   32'h0,          1'b1, 2'd0, 32'h0,          1'b0, 8'd9}, // R9
        '{OP_RD_WORD,  1'b1, 8'd3,   32'h0,          1'b0, 2'd0, 32'h0,          1'b0, 8'd9}, // R9
        '{5'd31,       1'b0, 8'd0,   32'h0,          1'b1, 2'd3, 32'h0,          1'b0, 8'd10}, // R10
        '{OP_NOP,      1'b0, 8'd0,   32'h0,          1'b0, 2'd0, 32'h0,          1'b0, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_op = '0;
    logic        req_sel = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [4:0]  req_cnt = '0;
    logic [31:0] req_data = '0;
    logic        busy, rsp_valid, rsp_last, rsp_lock;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_data;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    tagmem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_addr(req_addr), .req_cnt(req_cnt),
        .req_data(req_data), .uid(UID_V), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .rsp_lock(rsp_lock)
    );

    // Compare the current response against the expected beat.
    task automatic check(input string tag, input logic ev, input logic [1:0] eerr,
                         input logic [31:0] edata, input logic elock, input logic elast);
        total++;
        if (!ev) begin
            if (rsp_valid !== 1'b0) begin
                bad++;
                $display("FAIL %s: valid=%b expected 0", tag, rsp_valid);
            end
        end else if (rsp_valid !== 1'b1 || rsp_err !== eerr || rsp_data !== edata
                     || rsp_lock !== elock || rsp_last !== elast) begin
            bad++;
            $display("FAIL %s: v=%b err=%0d data=%h lock=%b last=%b expected v=1 err=%0d data=%h lock=%b last=%b",
                     tag, rsp_valid, rsp_err, rsp_data, rsp_lock, rsp_last,
                     eerr, edata, elock, elast);
        end
    endtask

    task automatic check_busy(input string tag, input logic eb);
        total++;
        if (busy !== eb) begin
            bad++;
            $display("FAIL %s: busy=%b expected %b", tag, busy, eb);
        end
    endtask

    // Drive one request for a cycle; on return the response is sampled-ready.
    task automatic send(input logic [4:0] op, input logic sel, input logic [7:0] addr,
                        input logic [4:0] cnt, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel;
        req_addr = addr;  req_cnt = cnt; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset response", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        check_busy("R1 reset busy", 1'b0);

        for (int i = 0; i < NV; i++) begin
            send(TBL[i].op, TBL[i].sel, TBL[i].addr, 5'd0, TBL[i].data);
            check($sformatf("R%0d vector %0d", TBL[i].rq, i), TBL[i].ev, TBL[i].eerr,
                  TBL[i].edata, TBL[i].elock, 1'b1);
        end

        // R5: multi-read burst with a request dropped mid-burst
        send(OP_WR_WORD, 1'b0, 8'd29, 5'd0, 32'h29);
        check("R2 write 29", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_WR_WORD, 1'b0, 8'd30, 5'd0, 32'h30);
        check("R2 write 30", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_WR_WORD, 1'b0, 8'd31, 5'd0, 32'h31);
        check("R2 write 31", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_RD_MULTI, 1'b0, 8'd29, 5'd2, 32'h0);
        check("R5 beat 1", 1'b1, 2'd0, 32'h29, 1'b0, 1'b0);
        check_busy("R5 busy during burst", 1'b1);
        req_valid = 1'b1; req_op = OP_WR_WORD; req_addr = 8'd29; req_data = 32'hBAD0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 beat 2", 1'b1, 2'd0, 32'h30, 1'b0, 1'b0);
        @(negedge clk);
        check("R5 beat 3 last", 1'b1, 2'd0, 32'h31, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 dropped request silent", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        check_busy("R5 busy clear", 1'b0);
        send(OP_RD_WORD, 1'b0, 8'd29, 5'd0, 32'h0);
        check("R5 dropped write had no effect", 1'b1, 2'd0, 32'h29, 1'b0, 1'b1);
        send(OP_RD_MULTI, 1'b0, 8'd30, 5'd2, 32'h0);
        check("R4 multi past end", 1'b1, 2'd2, 32'h0, 1'b0, 1'b1);
        send(OP_RD_MULTI, 1'b0, 8'd3, 5'd0, 32'h0);
        check("R5 single-word multi", 1'b1, 2'd0, 32'hA5A5_0001, 1'b1, 1'b1);

        // R8: inventory and quiet state
        send(OP_INVENTORY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R8 uid low", 1'b1, 2'd0, UID_V[31:0], 1'b0, 1'b0);
        @(negedge clk);
        check("R8 uid high", 1'b1, 2'd0, UID_V[63:32], 1'b0, 1'b1);
        send(OP_QUIET, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R8 quiet ack", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_INVENTORY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R8 quiet ignores inventory", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        send(OP_RD_WORD, 1'b0, 8'd29, 5'd0, 32'h0);
        check("R8 quiet still reads", 1'b1, 2'd0, 32'h29, 1'b0, 1'b1);
        send(OP_TO_READY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R9 back to ready", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);

        // R7: kill code lock and a matching kill
        send(OP_LK_KILL, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R7 lock kill", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_WR_KILL, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R7 write locked kill", 1'b1, 2'd1, 32'h0, 1'b0, 1'b1);
        send(OP_GET_INFO, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R6 info lock flags", 1'b1, 2'd0, 32'h0005_913C, 1'b0, 1'b1);
        send(OP_KILL, 1'b0, 8'd0, 5'd0, 32'hDEAD_BEEF);
        check("R7 kill ack", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_RD_WORD, 1'b0, 8'd29, 5'd0, 32'h0);
        check("R7 killed read silent", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        send(OP_TO_READY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R7 killed ready silent", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        send(OP_INVENTORY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R7 killed inventory silent", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);

        // R1: reset restores storage, locks and state
        do_reset();
        check("R1 reset response", 1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        send(OP_RD_WORD, 1'b0, 8'd3, 5'd0, 32'h0);
        check("R1 word cleared", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_GET_INFO, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R1 registers cleared", 1'b1, 2'd0, 32'h0, 1'b0, 1'b1);
        send(OP_KILL, 1'b0, 8'd0, 5'd0, 32'h1);
        check("R1 kill code zero", 1'b1, 2'd3, 32'h0, 1'b0, 1'b1);
        send(OP_INVENTORY, 1'b0, 8'd0, 5'd0, 32'h0);
        check("R1 active after reset", 1'b1, 2'd0, UID_V[31:0], 1'b0, 1'b0);
        @(negedge clk);
        check("R8 uid high after reset", 1'b1, 2'd0, UID_V[63:32], 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule